// File: doc/BRIEF.md
# Rotor Position Strobe Generator

This block watches three rotor-position sensor inputs and issues a single-cycle write-timing strobe each time it sees a valid rotor position. The strobe paces a downstream waveform data loader. The sensor pins are asynchronous to the block clock, so each one passes through a two-flop synchroniser. Edges are found by comparing each synchronised level with its level one clock earlier.

The block has two trigger modes. In edge mode, a per-pin enable mask and a 2-bit polarity control pick which sensor transitions count as a position event. In pattern mode, any transition on any sensor starts a comparison of the three synchronised levels against a programmable 3-bit expected pattern, and only a match fires the strobe. Every strobe can also raise a sticky interrupt flag. Software clears that flag with a one-cycle clear pulse.

Top module: `hall_pos_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `wr_strobe_o` and `irq_o` are 0.
- R2: A level change on a sensor pin that is set up before clock edge k produces the strobe in the cycle that follows edge k+2, which is two synchroniser stages plus one output register. The strobe is high for one cycle per detected event.
- R3: With `pattern_mode_i`=0, a qualifying edge on any pin whose bit in `pin_en_i` is 1 produces the strobe.
- R4: The `polarity_i` encoding is: 2'b01 means rising edges only, 2'b10 means falling edges only, 2'b11 means both, and 2'b00 means no edge counts, so edge mode never strobes.
- R5: In edge mode, a pin whose `pin_en_i` bit is 0 is ignored. With only bit 0 set, activity on sensor bits 1 and 2 never strobes. With the mask all zero, nothing strobes.
- R6: With `pattern_mode_i`=1, any transition on any sensor bit triggers a comparison. The strobe is asserted only if the synchronised levels in that same cycle equal `expect_i`. Bit i of `expect_i` is compared with sensor bit i. In this mode `pin_en_i` and `polarity_i` are ignored.
- R7: A strobe that coincides with `irq_en_i`=1 sets `irq_o` in the same cycle as the strobe. `irq_o` then stays at 1 with no further events.
- R8: A one-cycle `irq_clr_i` pulse clears `irq_o` on the next cycle. If a clear and a new interrupt-enabled event arrive in the same cycle, `irq_o` stays at 1.
- R9: Changing `pattern_mode_i`, `pin_en_i`, `polarity_i` or `expect_i` while the sensors are steady produces no strobe. A strobe only follows a synchronised sensor transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sens_i | input | 3 | Asynchronous rotor-position sensor pins |
| pattern_mode_i | input | 1 | 0 selects edge mode, 1 selects pattern mode |
| pin_en_i | input | 3 | Per-pin edge enable used in edge mode |
| polarity_i | input | 2 | Edge polarity select used in edge mode |
| expect_i | input | 3 | Expected sensor pattern used in pattern mode |
| irq_en_i | input | 1 | Lets a strobe set the interrupt flag |
| irq_clr_i | input | 1 | One-cycle clear pulse for the interrupt flag |
| wr_strobe_o | output | 1 | One-cycle write-timing strobe |
| irq_o | output | 1 | Sticky position-detect interrupt flag |

## Verification
Setting the interrupt flag and clearing it can land in the same cycle. When they do, the rule is that the set wins. The bench provokes this case directly: it drives a sensor transition, then places the `irq_clr_i` pulse on the exact clock edge at which that transition's strobe is registered, with the interrupt enabled. It also places random clear pulses across a long run of random sensor and control activity. Each cycle, the bench predicts the flag from its own model of the three-edge pipeline and compares `irq_o` against it, so a design where the clear wins fails on the coinciding cycle.

// File: rtl/hpd_pkg.sv
// Shared types for the rotor position strobe generator.
package hpd_pkg;
    // Edge polarity select: bit 0 admits rising edges, bit 1 admits falling edges.
    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } pol_e;
endpackage

// File: rtl/hpd_sync.sv
// hpd_sync: multi-stage synchroniser for each asynchronous sensor bit.
// Assumes: inputs are glitch-free levels; every stage resets to 0.
module hpd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift each bit one stage further from the asynchronous pin.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= async_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hpd_edge.sv
// hpd_edge: keeps the previous synchronised level and flags rising/falling edges.
// Assumes: history is never reloaded by control changes, so each edge is seen once.
module hpd_edge #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] hist_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] hist_q;

    // Record the level seen one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= level_i;
    end

    // Edge flags from current versus previous level.
    always_comb begin
        rise_o = level_i & ~hist_q;
        fall_o = ~level_i & hist_q;
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/hpd_trigger.sv
// hpd_trigger: picks the trigger condition for the current mode and registers
// the one-cycle write strobe. Also exposes the unregistered event for the flag.
// Assumes: controls are quasi-static and are sampled in the cycle of the edge.
module hpd_trigger #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] rise_i,
    input  logic [WIDTH-1:0] fall_i,
    input  logic             pattern_mode_i,
    input  logic [WIDTH-1:0] pin_en_i,
    input  logic [1:0]       polarity_i,
    input  logic [WIDTH-1:0] expect_i,
    output logic             event_o,
    output logic             strobe_o
);
    import hpd_pkg::*;

    logic [WIDTH-1:0] pol_hit;
    logic             edge_evt;
    logic             patt_evt;
    logic             strobe_q;

    // Edge qualification per the polarity select.
    always_comb begin
        unique case (pol_e'(polarity_i))
            POL_RISE: pol_hit = rise_i;
            POL_FALL: pol_hit = fall_i;
            POL_BOTH: pol_hit = rise_i | fall_i;
            default:  pol_hit = '0;
        endcase
    end

    // Mode select between masked edges and change-triggered pattern match.
    always_comb begin
        edge_evt = |(pol_hit & pin_en_i);
        patt_evt = (|(rise_i | fall_i)) && (level_i == expect_i);
        event_o  = pattern_mode_i ? patt_evt : edge_evt;
    end

    // Register the strobe so it is a clean single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= event_o;
    end

    assign strobe_o = strobe_q;

    // R6
    patt_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_mode_i && (level_i != expect_i)) |=> !strobe_o);

    // R5
    masked_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pattern_mode_i && (pin_en_i == '0)) |=> !strobe_o);

    // R4
    pol_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pattern_mode_i && (polarity_i == 2'b00)) |=> !strobe_o);
endmodule

// File: rtl/hpd_irq.sv
// hpd_irq: sticky interrupt flag, set by an enabled event, cleared by a pulse.
// Assumes: a set and a clear in the same cycle resolve in favour of the set.
module hpd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Hold the flag until cleared; a new set overrides a coincident clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (set_i && en_i)  flag_q <= 1'b1;
        else if (clr_i)          flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && en_i) |=> flag_o);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(set_i && en_i)) |=> !flag_o);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/hall_pos_detect.sv
// hall_pos_detect: top of the rotor position strobe generator.
// Synchronises three sensor pins, detects edges, selects edge or pattern
// triggering, emits a one-cycle write strobe and a sticky interrupt flag.
// Assumes: synchronous active-low reset; sensors low when reset is released.
module hall_pos_detect #(
    parameter int NUM_SENS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SENS-1:0] sens_i,
    input  logic                pattern_mode_i,
    input  logic [NUM_SENS-1:0] pin_en_i,
    input  logic [1:0]          polarity_i,
    input  logic [NUM_SENS-1:0] expect_i,
    input  logic                irq_en_i,
    input  logic                irq_clr_i,
    output logic                wr_strobe_o,
    output logic                irq_o
);
    logic [NUM_SENS-1:0] level;
    logic [NUM_SENS-1:0] hist;
    logic [NUM_SENS-1:0] rise;
    logic [NUM_SENS-1:0] fall;
    logic                pos_event;

    hpd_sync #(.WIDTH(NUM_SENS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sens_i), .sync_o(level)
    );

    hpd_edge #(.WIDTH(NUM_SENS)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(level),
        .hist_o(hist), .rise_o(rise), .fall_o(fall)
    );

    hpd_trigger #(.WIDTH(NUM_SENS)) u_trig (
        .clk(clk), .rst_n(rst_n), .level_i(level), .rise_i(rise), .fall_i(fall),
        .pattern_mode_i(pattern_mode_i), .pin_en_i(pin_en_i),
        .polarity_i(polarity_i), .expect_i(expect_i),
        .event_o(pos_event), .strobe_o(wr_strobe_o)
    );

    hpd_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(pos_event), .en_i(irq_en_i),
        .clr_i(irq_clr_i), .flag_o(irq_o)
    );

    // R9
    no_change_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == hist) |=> !wr_strobe_o);

    // R7
    strobe_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_event && irq_en_i) |=> (wr_strobe_o && irq_o));
endmodule

// File: tb/test_hall_pos_detect.sv
module test_hall_pos_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sens = '0;
    logic       pmode = 1'b0;
    logic [2:0] pen = '0;
    logic [1:0] pol = '0;
    logic [2:0] expv = '0;
    logic       ien = 1'b0;
    logic       iclr = 1'b0;
    logic       strb;
    logic       irq;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    string tag_ovr = "";

    // Bench model: sensor values driven for the coming edge and three before.
    logic [2:0] q0 = '0, q1 = '0, q2 = '0, q3 = '0;
    logic       exp_strb = 1'b0;
    logic       exp_irq = 1'b0;

    always #10 clk = ~clk;

    hall_pos_detect i_hall_pos_detect (
        .clk(clk), .rst_n(rst_n), .sens_i(sens), .pattern_mode_i(pmode),
        .pin_en_i(pen), .polarity_i(pol), .expect_i(expv),
        .irq_en_i(ien), .irq_clr_i(iclr), .wr_strobe_o(strb), .irq_o(irq)
    );

    // Expected event from requirement text: cur = synced level, prv = one clock earlier.
    function automatic logic model_evt(input logic [2:0] cur, input logic [2:0] prv,
                                       input logic m, input logic [2:0] en,
                                       input logic [1:0] p, input logic [2:0] ex);
        logic [2:0] r, f, hit;
        r = cur & ~prv;
        f = ~cur & prv;
        if (m) return (cur != prv) && (cur == ex);
        hit = (p[0] ? r : 3'b000) | (p[1] ? f : 3'b000);
        return |(hit & en);
    endfunction

    task automatic check(input string tag, input logic act, input logic expc, input string what);
        checks++;
        if (act !== expc) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, expc, $time);
        end
    endtask

    function automatic string strobe_tag();
        if (tag_ovr != "") return tag_ovr;
        if (pmode) return "R6";
        if (pol == 2'b00) return "R4";
        if (pen != 3'b111) return "R5";
        return "R3";
    endfunction

    // One cycle: drive inputs after a negedge, advance the model, check at the next negedge.
    task automatic step(input logic [2:0] s, input logic m, input logic [2:0] en,
                        input logic [1:0] p, input logic [2:0] ex, input logic ie,
                        input logic clr);
        logic e;
        string stag;
        sens = s; pmode = m; pen = en; pol = p; expv = ex; ien = ie; iclr = clr;
        q3 = q2; q2 = q1; q1 = q0; q0 = s;
        e = model_evt(q2, q3, m, en, p, ex);
        exp_strb = e;
        exp_irq  = (e && ie) ? 1'b1 : (clr ? 1'b0 : exp_irq);
        stag = strobe_tag();
        @(negedge clk);
        check(stag, strb, exp_strb, "strobe");
        check((tag_ovr != "") ? tag_ovr : "R7 R8", irq, exp_irq, "irq flag");
    endtask

    task automatic idle(input int n, input logic [2:0] s, input logic m, input logic [2:0] en,
                        input logic [1:0] p, input logic [2:0] ex, input logic ie);
        for (int i = 0; i < n; i++) step(s, m, en, p, ex, ie, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1", strb, 1'b0, "strobe in reset");
        check("R1", irq, 1'b0, "irq in reset");
        rst_n = 1'b1;
        tag_ovr = "R1";
        step(3'b000, 1'b0, 3'b111, 2'b11, 3'b000, 1'b1, 1'b0);
        // R2: single rising edge on bit 0; strobe after the third edge, for one cycle
        tag_ovr = "R2";
        step(3'b001, 1'b0, 3'b111, 2'b01, 3'b000, 1'b0, 1'b0);
        check("R2", strb, 1'b0, "strobe one edge after change");
        step(3'b001, 1'b0, 3'b111, 2'b01, 3'b000, 1'b0, 1'b0);
        check("R2", strb, 1'b0, "strobe two edges after change");
        step(3'b001, 1'b0, 3'b111, 2'b01, 3'b000, 1'b0, 1'b0);
        check("R2", strb, 1'b1, "strobe three edges after change");
        step(3'b001, 1'b0, 3'b111, 2'b01, 3'b000, 1'b0, 1'b0);
        check("R2", strb, 1'b0, "strobe width one cycle");
        // R4: polarity off, toggle bits; then falling only
        tag_ovr = "R4";
        step(3'b110, 1'b0, 3'b111, 2'b00, 3'b000, 1'b0, 1'b0);
        idle(4, 3'b110, 1'b0, 3'b111, 2'b00, 3'b000, 1'b0);
        step(3'b010, 1'b0, 3'b111, 2'b10, 3'b000, 1'b0, 1'b0);
        idle(4, 3'b010, 1'b0, 3'b111, 2'b10, 3'b000, 1'b0);
        // R5: only bit 0 enabled, activity on bits 1 and 2 ignored
        tag_ovr = "R5";
        step(3'b100, 1'b0, 3'b001, 2'b11, 3'b000, 1'b0, 1'b0);
        step(3'b010, 1'b0, 3'b001, 2'b11, 3'b000, 1'b0, 1'b0);
        step(3'b110, 1'b0, 3'b001, 2'b11, 3'b000, 1'b0, 1'b0);
        idle(4, 3'b110, 1'b0, 3'b001, 2'b11, 3'b000, 1'b0);
        check("R5", strb, 1'b0, "masked pins quiet");
        // R6: pattern mode, one match and one mismatch
        tag_ovr = "R6";
        step(3'b101, 1'b1, 3'b000, 2'b00, 3'b101, 1'b0, 1'b0);
        idle(4, 3'b101, 1'b1, 3'b000, 2'b00, 3'b101, 1'b0);
        step(3'b100, 1'b1, 3'b000, 2'b00, 3'b101, 1'b0, 1'b0);
        idle(4, 3'b100, 1'b1, 3'b000, 2'b00, 3'b101, 1'b0);
        // R9: control changes with steady sensors
        tag_ovr = "R9";
        step(3'b100, 1'b0, 3'b111, 2'b11, 3'b100, 1'b0, 1'b0);
        step(3'b100, 1'b1, 3'b111, 2'b11, 3'b100, 1'b0, 1'b0);
        step(3'b100, 1'b1, 3'b000, 2'b01, 3'b011, 1'b0, 1'b0);
        idle(3, 3'b100, 1'b0, 3'b100, 2'b10, 3'b000, 1'b0);
        // R8: clear coinciding with a new enabled event keeps the flag set
        tag_ovr = "R8";
        step(3'b000, 1'b0, 3'b111, 2'b11, 3'b000, 1'b1, 1'b0);
        step(3'b000, 1'b0, 3'b111, 2'b11, 3'b000, 1'b1, 1'b0);
        step(3'b000, 1'b0, 3'b111, 2'b11, 3'b000, 1'b1, 1'b1);
        check("R8", irq, 1'b1, "set wins over clear");
        idle(2, 3'b000, 1'b0, 3'b111, 2'b11, 3'b000, 1'b0);
        check("R7", irq, 1'b1, "flag sticky");
        step(3'b000, 1'b0, 3'b111, 2'b11, 3'b000, 1'b0, 1'b1);
        check("R8", irq, 1'b0, "clear pulse");
        // Random phase
        tag_ovr = "";
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] s;
            logic m;
            logic [2:0] en;
            logic [1:0] p;
            logic [2:0] ex;
            s = sens;
            for (int b = 0; b < 3; b++)
                if ($urandom_range(0, 5) == 0) s[b] = ~s[b];
            m  = pmode; en = pen; p = pol; ex = expv;
            if ($urandom_range(0, 40) == 0) m  = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 30) == 0) en = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 30) == 0) p  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 20) == 0) ex = 3'($urandom_range(0, 7));
            step(s, m, en, p, ex, ($urandom_range(0, 3) != 0), ($urandom_range(0, 9) == 0));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule